// File: doc/BRIEF.md
# Column Burst Sequencer

This block turns one column command into the column sequence a synchronous DRAM burst visits. A start pulse carries a start column, a read/write flag and a five-bit mode word that gives the burst size, the visiting order and the read latency. The mode word is captured on the start pulse. From the next cycle on, the block presents one column per clock with a valid flag and a last-beat flag.

A burst ends in one of four ways: it completes, a stop pulse arrives, a new start pulse arrives, or reset is asserted. A new start takes over at once. A stop lets the column already on the outputs stand as the final one. Writes always issue a single column, while reads follow the programmed size.

For every read column issued, a data-valid strobe rises a programmed number of cycles later, either 2 or 3. Only columns that were actually issued produce a strobe. A burst that is cut short therefore still delivers strobes for the columns it did issue.

Top module: `bseq_top`

## Requirements
- R1: While reset is asserted, and after it until the first start pulse, `col_valid`, `col_last`, `col_write` and `rd_valid` are 0.
- R2: The mode word is captured only on a start pulse. Bits [2:0] select the size: 0→1, 1→2, 2→4, 3→8, 7→whole row (256 columns). The codes 4, 5 and 6 give 1. Bit 3 selects interleaved order when set. Bit 4 selects a read latency of 3 when set and 2 when clear.
- R3: In sequential order with size BL, beat n shows the column whose upper bits equal those of the start column and whose low log2(BL) bits are (start + n) mod BL.
- R4: In interleaved order with size BL, beat n keeps the upper bits of the start column, and its low log2(BL) bits are the start's low bits XOR n.
- R5: A whole-row burst shows (start + n) mod 256 on beat n, ignores the order bit, never raises `col_last`, and runs until it is stopped, restarted or reset.
- R6: `col_last` is high exactly on beat BL-1 of a sized burst. Unless a new start pulse arrives, `col_valid` is low in the next cycle.
- R7: A start pulse with `cmd_write` high issues exactly one column (the start column) with `col_write` and `col_last` high, whatever size is programmed.
- R8: A stop pulse without a start pulse leaves the column shown in that cycle as the final one. `col_valid` is low from the next cycle on.
- R9: A start pulse during a burst, including one in the same cycle as a stop pulse, shows beat 0 of the new burst in the next cycle.
- R10: Each read column shown in cycle k raises `rd_valid` in cycle k+CL, where CL is the captured latency. Written columns never raise it. Columns issued before a stop or a restart still raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_word | input | 5 | Size code [2:0], order [3], latency [4] |
| cmd_start | input | 1 | Begin a burst |
| cmd_write | input | 1 | Burst is a write (single column) |
| cmd_stop | input | 1 | End the burst after the current column |
| start_col | input | 8 | First column of the burst |
| col_valid | output | 1 | A column is presented |
| col_addr | output | 8 | Presented column |
| col_last | output | 1 | Final beat of a sized burst |
| col_write | output | 1 | Presented column belongs to a write |
| rd_valid | output | 1 | Read data due in this cycle |

## Verification
Start columns are placed at the bottom, in the middle and at the top of their aligned blocks, and at 0xFF. This separates wrap inside the block from carry into the upper bits, and it separates sequential order from XOR order. A whole-row burst is run past column 255 and then stopped, and a second one has the order bit set, to show that the order bit has no effect there. Stops, restarts, start-with-stop and back-to-back starts are applied part-way through bursts of both latencies. They show that the column sequence is cut at the right beat while strobes for the columns already issued still arrive. The bad size codes and writes under an 8-beat mode confirm the single-column cases.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic [2:0] {
    LEN_1    = 3'd0,
    LEN_2    = 3'd1,
    LEN_4    = 3'd2,
    LEN_8    = 3'd3,
    LEN_ROW  = 3'd7
  } len_code_e;

  typedef struct packed {
    logic       lat3;
    logic       interleave;
    logic [2:0] len;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             cmd_write,
  input  mode_t            mode_in,
  input  logic [COL_W-1:0] start_col,
  output logic             busy,
  output logic             last,
  output logic             wr,
  output logic             lat3,
  output logic             il,
  output logic [COL_W-1:0] cnt,
  output logic [COL_W-1:0] base,
  output logic [COL_W-1:0] mask
);

  localparam int LG_W = $clog2(COL_W + 1);

  logic             busy_q, busy_d;
  logic [COL_W-1:0] cnt_q, cnt_d;
  logic [COL_W-1:0] base_q;
  logic [LG_W-1:0]  lg_q, lg_dec;
  logic             il_q, wr_q, lat3_q;
  logic             cfg_en;
  logic             row_mode;
  logic             last_c;

  // size decode of the incoming mode word
  always_comb begin
    case (mode_in.len)
      LEN_1:   lg_dec = '0;
      LEN_2:   lg_dec = LG_W'(1);
      LEN_4:   lg_dec = LG_W'(2);
      LEN_8:   lg_dec = LG_W'(3);
      LEN_ROW: lg_dec = LG_W'(COL_W);
      default: lg_dec = '0;
    endcase
  end

  // block mask: bit i set when i < log2(size)
  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign mask[i] = (LG_W'(i) < lg_q);
  end

  assign row_mode = (lg_q == LG_W'(COL_W));
  assign last_c   = busy_q && !row_mode && (cnt_q == mask);
  assign cfg_en   = cmd_start;

  // next state
  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (cmd_start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (cmd_stop) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      if (last_c) busy_d = 1'b0;
      else        cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      lg_q   <= '0;
      il_q   <= 1'b0;
      wr_q   <= 1'b0;
      lat3_q <= 1'b0;
    end else if (cfg_en) begin
      base_q <= start_col;
      lg_q   <= cmd_write ? '0 : lg_dec;
      il_q   <= mode_in.interleave && (mode_in.len != LEN_ROW);
      wr_q   <= cmd_write;
      lat3_q <= mode_in.lat3;
    end
  end

  assign busy = busy_q;
  assign last = last_c;
  assign wr   = wr_q;
  assign lat3 = lat3_q;
  assign il   = il_q;
  assign cnt  = cnt_q;
  assign base = base_q;

  a_r9_restart_beat0: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> (busy_q && cnt_q == '0 && base_q == $past(start_col)));

  a_r8_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stop && !cmd_start) |=> !busy_q);

  a_r6_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (last_c && !cmd_start) |=> !busy_q);

endmodule

// File: rtl/bseq_order.sv
module bseq_order #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] cnt,
  input  logic [COL_W-1:0] mask,
  input  logic             il,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] low_seq, low_il;

  assign low_seq = base + cnt;
  assign low_il  = base ^ cnt;
  assign col     = (base & ~mask) | ((il ? low_il : low_seq) & mask);

endmodule

// File: rtl/bseq_rdpipe.sv
module bseq_rdpipe #(
  parameter int MAX_CL = 3,
  localparam int CL_W = $clog2(MAX_CL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic [CL_W-1:0] cl,
  output logic            rd_valid
);

  logic [MAX_CL-1:0] sr_q, sr_d;

  // a beat with latency c enters at slot c-1 and walks down to slot 0
  for (genvar i = 0; i < MAX_CL; i++) begin : g_slot
    if (i == MAX_CL - 1) begin : g_top
      assign sr_d[i] = issue && (cl == CL_W'(i + 1));
    end else begin : g_mid
      assign sr_d[i] = sr_q[i+1] | (issue && (cl == CL_W'(i + 1)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rd_valid = sr_q[0];

  a_r10_lat2_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && cl == CL_W'(2)) |-> ##2 rd_valid);

  a_r10_lat3_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && cl == CL_W'(3)) |-> ##3 rd_valid);

endmodule

// File: rtl/bseq_top.sv
module bseq_top
  import bseq_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MAX_CL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       mode_word,
  input  logic             cmd_start,
  input  logic             cmd_write,
  input  logic             cmd_stop,
  input  logic [COL_W-1:0] start_col,
  output logic             col_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             col_last,
  output logic             col_write,
  output logic             rd_valid
);

  localparam int CL_W = $clog2(MAX_CL + 1);

  mode_t            mode_in;
  logic             busy, last, wr, lat3, il;
  logic [COL_W-1:0] cnt, base, mask;
  logic [CL_W-1:0]  cl;
  logic             issue;

  assign mode_in = mode_t'(mode_word);

  bseq_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .cmd_stop  (cmd_stop),
    .cmd_write (cmd_write),
    .mode_in   (mode_in),
    .start_col (start_col),
    .busy      (busy),
    .last      (last),
    .wr        (wr),
    .lat3      (lat3),
    .il        (il),
    .cnt       (cnt),
    .base      (base),
    .mask      (mask)
  );

  bseq_order #(.COL_W(COL_W)) u_order (
    .base (base),
    .cnt  (cnt),
    .mask (mask),
    .il   (il),
    .col  (col_addr)
  );

  assign issue = busy && !wr;
  assign cl    = lat3 ? CL_W'(3) : CL_W'(2);

  bseq_rdpipe #(.MAX_CL(MAX_CL)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (issue),
    .cl       (cl),
    .rd_valid (rd_valid)
  );

  assign col_valid = busy;
  assign col_last  = last;
  assign col_write = busy && wr;

  a_r7_write_single: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && col_write) |-> col_last);

  a_r7_write_no_strobe_src: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_write) |=> (col_addr == $past(start_col)));

endmodule

// File: tb/bseq_top_tb.sv
`timescale 1ns/100ps
module bseq_top_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] mode_word = '0;
  logic       cmd_start = 1'b0, cmd_write = 1'b0, cmd_stop = 1'b0;
  logic [7:0] start_col = '0;
  logic       col_valid, col_last, col_write, rd_valid;
  logic [7:0] col_addr;

  int checks = 0, failures = 0;
  string cur_tag = "R1";

  always #2.5 clk = ~clk;

  bseq_top u_dut (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .cmd_start(cmd_start),
    .cmd_write(cmd_write), .cmd_stop(cmd_stop), .start_col(start_col),
    .col_valid(col_valid), .col_addr(col_addr), .col_last(col_last),
    .col_write(col_write), .rd_valid(rd_valid)
  );

  // reference model
  int m_busy = 0, m_cnt = 0, m_start = 0, m_bl = 1, m_il = 0, m_wr = 0, m_cl = 2;
  int cyc = 0;
  int due[$];

  function automatic int size_of(input logic [2:0] c);
    case (c)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 256;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; due.delete();
    end else begin
      if (m_busy && !m_wr) due.push_back(cyc + m_cl);
      if (cmd_start) begin
        m_busy = 1; m_cnt = 0; m_start = start_col; m_wr = cmd_write;
        m_bl = cmd_write ? 1 : size_of(mode_word[2:0]);
        m_il = (m_bl == 256) ? 0 : mode_word[3];
        m_cl = mode_word[4] ? 3 : 2;
      end else if (cmd_stop) begin
        m_busy = 0;
      end else if (m_busy) begin
        if (m_bl != 256 && m_cnt == m_bl - 1) m_busy = 0;
        else m_cnt = (m_cnt + 1) % 256;
      end
    end
    cyc++;
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    int off, base, exp_addr, exp_last, exp_rv;
    for (int i = due.size() - 1; i >= 0; i--) if (due[i] < cyc) due.delete(i);
    exp_rv = 0;
    foreach (due[i]) if (due[i] == cyc) exp_rv = 1;
    exp_last = (m_busy && m_bl != 256 && m_cnt == m_bl - 1) ? 1 : 0;
    chk(cur_tag, "col_valid", int'(col_valid), m_busy);
    chk("R6", "col_last", int'(col_last), exp_last);
    chk("R7", "col_write", int'(col_write), (m_busy && m_wr) ? 1 : 0);
    chk("R10", "rd_valid", int'(rd_valid), exp_rv);
    if (m_busy) begin
      off  = m_start % m_bl;
      base = m_start - off;
      if (m_il) exp_addr = base + (off ^ m_cnt);
      else      exp_addr = (base + (off + m_cnt) % m_bl) % 256;
      chk(cur_tag, "col_addr", int'(col_addr), exp_addr);
    end
  end

  function automatic logic [4:0] mk(input bit l3, input bit il, input logic [2:0] len);
    return {l3, il, len};
  endfunction

  task automatic step(input bit st, input bit sp, input bit wr,
                      input logic [4:0] md, input logic [7:0] c);
    @(posedge clk); #1;
    cmd_start = st; cmd_stop = sp; cmd_write = wr; mode_word = md; start_col = c;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 5'h1F, 8'h00);
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cur_tag = "R1";
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(3);

    cur_tag = "R3";
    step(1, 0, 0, mk(0, 0, 3'd2), 8'h0D); idle(7);
    step(1, 0, 0, mk(1, 0, 3'd3), 8'h05); idle(11);
    step(1, 0, 0, mk(0, 0, 3'd3), 8'hF8); idle(10);

    cur_tag = "R4";
    step(1, 0, 0, mk(1, 1, 3'd3), 8'h2B); idle(11);
    step(1, 0, 0, mk(0, 1, 3'd2), 8'h36); idle(7);
    step(1, 0, 0, mk(0, 1, 3'd1), 8'h91); idle(5);

    cur_tag = "R2";
    step(1, 0, 0, mk(0, 0, 3'd5), 8'h77); idle(4);
    step(1, 0, 0, mk(1, 1, 3'd4), 8'h13); idle(4);
    step(1, 0, 0, mk(0, 0, 3'd1), 8'hFF); idle(5);
    step(1, 0, 0, mk(1, 0, 3'd0), 8'h42); idle(5);

    cur_tag = "R5";
    step(1, 0, 0, mk(0, 0, 3'd7), 8'hFC); idle(262);
    step(0, 1, 0, 5'h00, 8'h00); idle(5);
    step(1, 0, 0, mk(1, 1, 3'd7), 8'h13); idle(20);
    step(0, 1, 0, 5'h00, 8'h00); idle(5);

    cur_tag = "R7";
    step(1, 0, 1, mk(0, 0, 3'd3), 8'h44); idle(4);
    step(1, 0, 1, mk(1, 0, 3'd7), 8'hA0);
    step(1, 0, 0, mk(0, 0, 3'd2), 8'hA1); idle(7);

    cur_tag = "R8";
    step(1, 0, 0, mk(1, 0, 3'd3), 8'h80); idle(2);
    step(0, 1, 0, 5'h00, 8'h00); idle(6);
    step(0, 1, 0, 5'h00, 8'h00); idle(3);
    step(1, 0, 0, mk(0, 1, 3'd2), 8'h59);
    step(0, 1, 0, 5'h00, 8'h00); idle(5);

    cur_tag = "R9";
    step(1, 0, 0, mk(1, 0, 3'd3), 8'h20); idle(2);
    step(1, 0, 0, mk(0, 0, 3'd2), 8'h41); idle(7);
    step(1, 0, 0, mk(0, 0, 3'd3), 8'h60); idle(1);
    step(1, 1, 0, mk(1, 1, 3'd2), 8'h6E); idle(7);
    step(1, 0, 0, mk(1, 0, 3'd3), 8'h10);
    step(1, 0, 0, mk(0, 1, 3'd3), 8'h1A);
    step(1, 0, 0, mk(1, 0, 3'd1), 8'h33); idle(8);

    cur_tag = "R1";
    rst_n = 1'b0;
    step(1, 0, 0, mk(0, 0, 3'd3), 8'h00);
    idle(3);
    #1 rst_n = 1'b1;
    idle(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule